// File: doc/BRIEF.md
# Dual-Alarm Free-Running Timer

A word-addressed timer peripheral built around a 32-bit counter that advances once per clock and wraps from all-ones back to zero. Two compare registers watch the counter. When the counter equals a compare value, a sticky status flag for that alarm is raised on the following clock edge. A per-alarm enable bit decides whether that flag drives the single interrupt line.

Software controls the block through a small register window. Two of its controls act as levels rather than pulses. The soft-hold bit pins the counter at its reset value for as long as software leaves it set. Each per-alarm clear bit keeps its status flag at zero, and blocks new matches from raising it, until software removes the bit. Read data comes back one cycle after the access, over a simple select / write-enable handshake.

Top module: `dual_alarm_timer`

## Requirements
- R1: Word addresses select registers as follows: 0 soft-hold, 1 interrupt enable, 2 flag clear, 3 unused, 4 compare 0, 5 compare 1, 6 status, 7 counter. A read access (`sel`=1, `wr_en`=0) places the addressed value on `rdata` at the next clock edge, and `rdata` holds between reads.
- R2: Only bit 0 of the soft-hold register is stored. Bits 31:1 read as zero.
- R3: While the soft-hold bit is 1, the counter is loaded with the reset value on every edge, starting at the edge after the write. While it is 0, the counter runs.
- R4: A running counter increases by one each clock and wraps from 0xFFFFFFFF to 0. The parameter `RESET_VAL` gives the reset value, which defaults to 0.
- R5: Status bit n (bit 0 for compare 0, bit 1 for compare 1) becomes 1 on the edge after the counter equals compare n. It then stays at 1 until it is cleared.
- R6: While clear bit n is 1, status bit n is 0 from the next edge on, and counter matches do not set it again.
- R7: `irq` is the OR over n of (status bit n AND enable bit n). It follows the registers with no added delay.
- R8: Writes to the status and counter addresses have no effect.
- R9: Both compare registers store and return all 32 bits. The enable and clear registers store bits 1:0 and read zero above them.
- R10: The unused word at address 3 reads as zero, and writes to it have no effect.
- R11: After hardware reset (`rst_n` low), the soft-hold, enable, clear, compare and status registers are all 0, `rdata` is 0, `irq` is 0, and the counter holds `RESET_VAL`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel | input | 1 | Access strobe for this cycle |
| wr_en | input | 1 | 1 = write access, 0 = read access |
| addr | input | 3 | Word address of the register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| irq | output | 1 | Combined enabled alarm interrupt |

## Verification
The bench sets `RESET_VAL` to 0xFFFFFF00, so the counter starts 256 counts below the wrap. A compare value of zero then fires only after the counter rolls over, which checks the wrap and the hit at zero within a few hundred cycles. The same parameter value gives a reset value that is not zero, so the soft-hold reload can be told apart from an ordinary clear to zero. `ADDR_W` and `N_ALM` keep their defaults, because the register layout depends on them.

// File: rtl/timer_pkg.sv
package timer_pkg;
  localparam int unsigned WORD_W = 32;

  // Word addresses inside the register window
  localparam int unsigned ADR_HOLD     = 0;
  localparam int unsigned ADR_ENABLE   = 1;
  localparam int unsigned ADR_CLEAR    = 2;
  localparam int unsigned ADR_UNUSED   = 3;
  localparam int unsigned ADR_CMP_BASE = 4;
  localparam int unsigned ADR_STATUS   = 6;
  localparam int unsigned ADR_COUNT    = 7;

  // Counter step: reload while held, otherwise +1 with natural wrap
  function automatic logic [WORD_W-1:0] count_step(input logic [WORD_W-1:0] cur,
                                                   input logic hold,
                                                   input logic [WORD_W-1:0] reload);
    return hold ? reload : cur + WORD_W'(1);
  endfunction

  // Sticky flag with a level-held clear that wins over a new hit
  function automatic logic flag_step(input logic cur, input logic hit, input logic clr);
    return ~clr & (cur | hit);
  endfunction

  // Compare event
  function automatic logic is_match(input logic [WORD_W-1:0] cnt,
                                    input logic [WORD_W-1:0] cmp);
    return cnt == cmp;
  endfunction
endpackage

// File: rtl/timer_count.sv
module timer_count
  import timer_pkg::*;
#(
  parameter logic [WORD_W-1:0] RESET_VAL = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hold,
  output logic [WORD_W-1:0] cnt
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= RESET_VAL;
    else        cnt <= count_step(cnt, hold, RESET_VAL);
  end
endmodule

// File: rtl/timer_alarm_slot.sv
module timer_alarm_slot
  import timer_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WORD_W-1:0] cnt,
  input  logic [WORD_W-1:0] cmp,
  input  logic              clr,
  output logic              hit,
  output logic              flag
);
  assign hit = is_match(cnt, cmp);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag <= 1'b0;
    else        flag <= flag_step(flag, hit, clr);
  end
endmodule

// File: rtl/timer_bus_regs.sv
module timer_bus_regs
  import timer_pkg::*;
#(
  parameter int unsigned ADDR_W = 3,
  parameter int unsigned N_ALM  = 2
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         sel,
  input  logic                         wr_en,
  input  logic [ADDR_W-1:0]            addr,
  input  logic [WORD_W-1:0]            wdata,
  input  logic [N_ALM-1:0]             status,
  input  logic [WORD_W-1:0]            cnt,
  output logic [WORD_W-1:0]            rdata,
  output logic                         hold,
  output logic [N_ALM-1:0]             enable,
  output logic [N_ALM-1:0]             clear,
  output logic [N_ALM-1:0][WORD_W-1:0] cmp
);
  logic wr_acc;
  logic rd_acc;
  logic [WORD_W-1:0] rd_mux;

  assign wr_acc = sel & wr_en;
  assign rd_acc = sel & ~wr_en;

  // Control words
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold   <= 1'b0;
      enable <= '0;
      clear  <= '0;
    end else if (wr_acc) begin
      if (addr == ADDR_W'(ADR_HOLD))   hold   <= wdata[0];
      if (addr == ADDR_W'(ADR_ENABLE)) enable <= wdata[N_ALM-1:0];
      if (addr == ADDR_W'(ADR_CLEAR))  clear  <= wdata[N_ALM-1:0];
    end
  end

  // Compare words, one per alarm
  for (genvar i = 0; i < N_ALM; i++) begin : g_cmp
    localparam int unsigned MY_ADR = ADR_CMP_BASE + i;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                  cmp[i] <= '0;
      else if (wr_acc && addr == ADDR_W'(MY_ADR))  cmp[i] <= wdata;
    end
  end

  // Read selection
  always_comb begin
    rd_mux = '0;
    if (addr == ADDR_W'(ADR_HOLD))   rd_mux = WORD_W'(hold);
    if (addr == ADDR_W'(ADR_ENABLE)) rd_mux = WORD_W'(enable);
    if (addr == ADDR_W'(ADR_CLEAR))  rd_mux = WORD_W'(clear);
    if (addr == ADDR_W'(ADR_UNUSED)) rd_mux = '0;
    if (addr == ADDR_W'(ADR_STATUS)) rd_mux = WORD_W'(status);
    if (addr == ADDR_W'(ADR_COUNT))  rd_mux = cnt;
    for (int i = 0; i < N_ALM; i++) begin
      if (addr == ADDR_W'(ADR_CMP_BASE + i)) rd_mux = cmp[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rdata <= '0;
    else if (rd_acc) rdata <= rd_mux;
  end
endmodule

// File: rtl/dual_alarm_timer.sv
module dual_alarm_timer
  import timer_pkg::*;
#(
  parameter int unsigned       ADDR_W    = 3,
  parameter int unsigned       N_ALM     = 2,
  parameter logic [WORD_W-1:0] RESET_VAL = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [WORD_W-1:0] wdata,
  output logic [WORD_W-1:0] rdata,
  output logic              irq
);
  // Named internal events, visible to the bound checker
  logic                         hold_q;
  logic [WORD_W-1:0]            cnt_val;
  logic [N_ALM-1:0]             hit_vec;
  logic [N_ALM-1:0]             stat_vec;
  logic [N_ALM-1:0]             en_vec;
  logic [N_ALM-1:0]             clr_vec;
  logic [N_ALM-1:0][WORD_W-1:0] cmp_vec;

  timer_bus_regs #(.ADDR_W(ADDR_W), .N_ALM(N_ALM)) u_regs (
    .clk    (clk),
    .rst_n  (rst_n),
    .sel    (sel),
    .wr_en  (wr_en),
    .addr   (addr),
    .wdata  (wdata),
    .status (stat_vec),
    .cnt    (cnt_val),
    .rdata  (rdata),
    .hold   (hold_q),
    .enable (en_vec),
    .clear  (clr_vec),
    .cmp    (cmp_vec)
  );

  timer_count #(.RESET_VAL(RESET_VAL)) u_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .hold  (hold_q),
    .cnt   (cnt_val)
  );

  for (genvar i = 0; i < N_ALM; i++) begin : g_slot
    timer_alarm_slot u_slot (
      .clk   (clk),
      .rst_n (rst_n),
      .cnt   (cnt_val),
      .cmp   (cmp_vec[i]),
      .clr   (clr_vec[i]),
      .hit   (hit_vec[i]),
      .flag  (stat_vec[i])
    );
  end

  assign irq = |(stat_vec & en_vec);
endmodule

// File: rtl/timer_chk.sv
module timer_chk
  import timer_pkg::*;
#(
  parameter int unsigned       ADDR_W    = 3,
  parameter int unsigned       N_ALM     = 2,
  parameter logic [WORD_W-1:0] RESET_VAL = '0
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sel,
  input logic              wr_en,
  input logic [ADDR_W-1:0] addr,
  input logic [WORD_W-1:0] rdata,
  input logic              irq,
  input logic              hold,
  input logic [WORD_W-1:0] cnt,
  input logic [N_ALM-1:0]  hit,
  input logic [N_ALM-1:0]  stat,
  input logic [N_ALM-1:0]  en,
  input logic [N_ALM-1:0]  clr
);
  p_hold_reload_r3: assert property (@(posedge clk) disable iff (!rst_n)
    hold |=> (cnt == RESET_VAL));

  p_count_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !hold |=> (cnt == WORD_W'($past(cnt) + WORD_W'(1))));

  p_hit_sets_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (|(hit & ~clr)) |=> ((stat & $past(hit & ~clr)) == $past(hit & ~clr)));

  p_flag_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (|(stat & ~clr)) |=> ((stat & $past(stat & ~clr)) == $past(stat & ~clr)));

  p_clear_holds_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (|clr) |=> ((stat & $past(clr)) == '0));

  p_irq_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(|(stat & en)) |-> !irq);

  p_irq_fires_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (|(stat & en)) |-> irq);

  p_hold_upper_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && !wr_en && addr == ADDR_W'(ADR_HOLD)) |=> (rdata[WORD_W-1:1] == '0));

  p_unused_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && !wr_en && addr == ADDR_W'(ADR_UNUSED)) |=> (rdata == '0));

  p_rdata_stable_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !(sel && !wr_en) |=> $stable(rdata));
endmodule

bind dual_alarm_timer timer_chk #(
  .ADDR_W    (ADDR_W),
  .N_ALM     (N_ALM),
  .RESET_VAL (RESET_VAL)
) u_chk (
  .clk   (clk),
  .rst_n (rst_n),
  .sel   (sel),
  .wr_en (wr_en),
  .addr  (addr),
  .rdata (rdata),
  .irq   (irq),
  .hold  (hold_q),
  .cnt   (cnt_val),
  .hit   (hit_vec),
  .stat  (stat_vec),
  .en    (en_vec),
  .clr   (clr_vec)
);

// File: tb/sim_dual_alarm_timer.sv
`timescale 1ns/1ps
module sim_dual_alarm_timer;
  localparam logic [31:0] RV = 32'hFFFF_FF00;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sel = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;

  int n_chk = 0;
  int n_err = 0;
  int cyc = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  dual_alarm_timer #(.RESET_VAL(RV)) u0 (
    .clk(clk), .rst_n(rst_n), .sel(sel), .wr_en(wr_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq)
  );

  // Behavioural reference state
  logic [31:0] m_cnt = RV, m_cmp0 = '0, m_cmp1 = '0, m_rd = '0;
  logic        m_hold = 1'b0;
  logic [1:0]  m_en = '0, m_clr = '0, m_st = '0;

  function automatic logic [31:0] m_read(input logic [2:0] a);
    case (a)
      3'd0: return {31'd0, m_hold};
      3'd1: return {30'd0, m_en};
      3'd2: return {30'd0, m_clr};
      3'd4: return m_cmp0;
      3'd5: return m_cmp1;
      3'd6: return {30'd0, m_st};
      3'd7: return m_cnt;
      default: return 32'd0;
    endcase
  endfunction

  always @(posedge clk) begin
    logic [1:0]  hits;
    logic [31:0] next_cnt;
    if (!rst_n) begin
      m_cnt = RV; m_cmp0 = '0; m_cmp1 = '0; m_rd = '0;
      m_hold = 1'b0; m_en = '0; m_clr = '0; m_st = '0;
    end else begin
      hits = '0;
      if (m_cnt == m_cmp0) hits[0] = 1'b1;
      if (m_cnt == m_cmp1) hits[1] = 1'b1;
      next_cnt = m_hold ? RV : m_cnt + 32'd1;
      if (sel && !wr_en) m_rd = m_read(addr);
      m_st = (m_st | hits) & ~m_clr;
      m_cnt = next_cnt;
      if (sel && wr_en) begin
        case (addr)
          3'd0: m_hold = wdata[0];
          3'd1: m_en = wdata[1:0];
          3'd2: m_clr = wdata[1:0];
          3'd4: m_cmp0 = wdata;
          3'd5: m_cmp1 = wdata;
          default: ;
        endcase
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Compare against the model on every clock, away from the edge
  always @(negedge clk) begin
    if (cyc > 2) begin
      chk(irq === |(m_st & m_en), "R7 irq vs model", {31'd0, irq}, {31'd0, |(m_st & m_en)});
      chk(rdata === m_rd, "R1 rdata vs model", rdata, m_rd);
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000 && !done) begin
      chk(1'b0, "watchdog", 32'(cyc), 32'd20000);
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); sel = 1'b1; wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); sel = 1'b0; wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk); sel = 1'b1; wr_en = 1'b0; addr = a;
    @(negedge clk); sel = 1'b0;
    chk(rdata === exp, tag, rdata, exp);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(rdata === 32'd0, "R11 rdata in reset", rdata, 32'd0);
    chk(irq === 1'b0, "R11 irq in reset", {31'd0, irq}, 32'd0);
    rst_n = 1'b1;

    // R2 / R3: hold the counter first
    wr(3'd0, 32'hFFFF_FFFF);
    rd(3'd0, 32'd1, "R2 hold bit only");
    rd(3'd1, 32'd0, "R11 enable reset");
    rd(3'd2, 32'd0, "R11 clear reset");
    rd(3'd4, 32'd0, "R11 cmp0 reset");
    rd(3'd5, 32'd0, "R11 cmp1 reset");
    rd(3'd6, 32'd0, "R11 status reset");
    rd(3'd7, RV, "R3 counter held");
    idle(5);
    rd(3'd7, RV, "R3 counter still held");

    // R9: storage widths
    wr(3'd4, 32'hA5A5_5A5A); rd(3'd4, 32'hA5A5_5A5A, "R9 cmp0 full word");
    wr(3'd5, 32'h1234_5678); rd(3'd5, 32'h1234_5678, "R9 cmp1 full word");
    wr(3'd1, 32'hFFFF_FFFF); rd(3'd1, 32'd3, "R9 enable width");
    wr(3'd1, 32'd0);
    wr(3'd2, 32'hFFFF_FFFD); rd(3'd2, 32'd1, "R9 clear width");
    wr(3'd2, 32'd0);

    // R10 / R8: ignored writes
    wr(3'd3, 32'hDEAD_BEEF); rd(3'd3, 32'd0, "R10 unused word");
    wr(3'd6, 32'd3);         rd(3'd6, 32'd0, "R8 status read-only");
    wr(3'd7, 32'h0000_1234); rd(3'd7, RV, "R8 counter read-only");

    // R5 / R7: both alarms fire, enable gates irq
    wr(3'd4, RV + 32'd30);
    wr(3'd5, RV + 32'd60);
    wr(3'd0, 32'd0);
    idle(80);
    rd(3'd6, 32'd3, "R5 both flags set");
    chk(irq === 1'b0, "R7 irq masked", {31'd0, irq}, 32'd0);
    wr(3'd1, 32'd1);
    chk(irq === 1'b1, "R7 irq enabled", {31'd0, irq}, 32'd1);

    // R6: clear held
    wr(3'd2, 32'd1);
    rd(3'd6, 32'd2, "R6 flag0 cleared");
    chk(irq === 1'b0, "R7 irq after clear", {31'd0, irq}, 32'd0);
    wr(3'd1, 32'd2);
    chk(irq === 1'b1, "R7 irq from alarm1", {31'd0, irq}, 32'd1);
    wr(3'd4, m_cnt + 32'd8);
    idle(20);
    rd(3'd6, 32'd2, "R6 match blocked while clear held");
    wr(3'd2, 32'd0);
    rd(3'd6, 32'd2, "R6 release keeps flag0 low");
    wr(3'd4, m_cnt + 32'd8);
    idle(20);
    rd(3'd6, 32'd3, "R5 flag0 set again");

    // R4: wrap through zero, compare 1 at zero
    wr(3'd2, 32'd3);
    wr(3'd2, 32'd0);
    wr(3'd5, 32'd0);
    idle(300);
    rd(3'd6, 32'd2, "R4 hit at zero after wrap");
    @(negedge clk); sel = 1'b1; wr_en = 1'b0; addr = 3'd7;
    @(negedge clk); sel = 1'b0;
    chk(rdata < 32'd400, "R4 counter wrapped", rdata, 32'd400);

    // R3: hold again reloads
    wr(3'd0, 32'd1);
    rd(3'd7, RV, "R3 reload on hold");
    wr(3'd0, 32'd0);
    idle(4);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule